// File: doc/BRIEF.md
# ATA Strobe Timing Generator

This block drives the active-low read strobe (`diorN`) and write strobe (`diowN`) of a parallel ATA channel. It handles programmed I/O and multiword DMA cycles. Each of the attached devices has its own 32-bit timing word, written through a small write-only configuration port. The word holds packed phase lengths. Data-register cycles and task-file (command) register cycles each have their own setup, active and inactive counts. Every count is stored as the number of clocks minus one.

A transfer request gives the device, the direction, the register class and whether the transfer is a DMA transfer. The block accepts a request only when idle and copies the device's timing word at that moment. It then runs three phases. First comes a setup phase with both strobes high. Next comes an active phase with one strobe low. Last comes a recovery phase with the strobe released. A one-clock `done` pulse marks the end. When a request follows directly on the previous one, for the same device and the same register class, the setup phase is skipped.

Top module: `ata_strobe_gen`

## Requirements
- R1: While reset is asserted and after it is released, both strobes are high and `busy`, `done`, `rdCapture` and `fifoEn` are low. Reset clears every timing word to zero, so a later transfer has a setup, active and recovery phase of exactly one clock each.
- R2: For a data-register transfer, the strobe stays low for (word[8:4] + 1) clocks. The recovery phase after it lasts (word[3:0] + 1) clocks.
- R3: For a task-file transfer (`reqTaskFile`=1), the strobe stays low for (word[17:13] + 1) clocks. The recovery phase lasts (word[12:9] + 1) clocks.
- R4: Before the first strobe, a setup phase holds both strobes high while `busy` is high. It lasts (word[24:22] + 1) clocks for data-register transfers and (word[27:25] + 1) clocks for task-file transfers.
- R5: A read (`reqWrite`=0) pulls only `diorN` low, and a write pulls only `diowN` low. Both strobes are never low together.
- R6: During a read, `rdCapture` is high for exactly one clock, the last clock in which the strobe is low. It never rises during a write.
- R7: `busy` rises in the clock after a request is accepted. It stays high until `done`, which is a single-clock pulse in the last recovery clock. `busy` is low in the following clock.
- R8: `reqValid` is ignored while `busy` is high. A request raised and withdrawn during a transfer starts no further transfer.
- R9: Setup is skipped only in one case. The request must be accepted in the first idle clock after `done`, for the same device and the same register class as the transfer that just ended. In that case the strobe falls in the first busy clock. A different device, a different class, or a later acceptance all keep the setup phase.
- R10: The timing word is copied when a request is accepted. A configuration write during a transfer leaves that transfer's timing unchanged and applies from the next accepted request.
- R11: Writing the word of one device (`cfgDev`) leaves the words of the other devices unchanged. Each transfer uses the word of `reqDev`.
- R12: `fifoEn` is high during a transfer only when word bit 31 is set, `reqDma` is high and the transfer is a data-register transfer. It is low for PIO transfers, for task-file transfers and whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Timing word write enable |
| cfgDev | input | 1 | Device whose timing word is written |
| cfgWord | input | 32 | Timing word value |
| reqValid | input | 1 | Transfer request, taken when idle |
| reqDev | input | 1 | Device addressed by the request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqTaskFile | input | 1 | 1 = task-file register, 0 = data register |
| reqDma | input | 1 | 1 = multiword DMA data transfer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock pulse in the last recovery clock |
| diorN | output | 1 | Read strobe, active low |
| diowN | output | 1 | Write strobe, active low |
| rdCapture | output | 1 | Read data sample point |
| fifoEn | output | 1 | FIFO enable for the current transfer |

## Verification
The bench measures each phase length at the pins. It covers fields at zero and at their maximum, so a design that mixed up the data and task-file fields, or dropped the plus-one, would show wrong clock counts. It checks the back-to-back setup skip for the matching case, for a different class, for a different device and after a two-clock gap. A design that skipped setup too freely, or never skipped it, is caught there. Further tests write a new word in the middle of a transfer, pulse a request during a busy phase, and reset in the middle of a strobe. A design without a snapshot, without the idle check, or one that kept the old words after reset would produce the wrong timing or a stray transfer.

// File: rtl/ata_strobe_pkg.sv
package ata_strobe_pkg;

  localparam int WORD_W = 32;
  localparam int CNT_W  = 5;

  // timing word field positions
  localparam int DINACT_LO = 0;
  localparam int DINACT_W  = 4;
  localparam int DACT_LO   = 4;
  localparam int DACT_W    = 5;
  localparam int CINACT_LO = 9;
  localparam int CINACT_W  = 4;
  localparam int CACT_LO   = 13;
  localparam int CACT_W    = 5;
  localparam int DSETUP_LO = 22;
  localparam int DSETUP_W  = 3;
  localparam int CSETUP_LO = 25;
  localparam int CSETUP_W  = 3;
  localparam int FIFO_BIT  = 31;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_ACTIVE  = 2'd2,
    ST_RECOVER = 2'd3
  } phase_e;

  typedef struct packed {
    logic   takeSnap;
    logic   cntLoad;
    phase_e cntSel;
    logic   release_;
  } ctrl_s;

  function automatic logic [CNT_W-1:0] phaseCount(
    input logic [WORD_W-1:0] word,
    input logic              taskFile,
    input phase_e            sel
  );
    logic [CNT_W-1:0] val;
    val = '0;
    unique case (sel)
      ST_SETUP:
        val = taskFile ? CNT_W'(word[CSETUP_LO +: CSETUP_W])
                       : CNT_W'(word[DSETUP_LO +: DSETUP_W]);
      ST_ACTIVE:
        val = taskFile ? CNT_W'(word[CACT_LO +: CACT_W])
                       : CNT_W'(word[DACT_LO +: DACT_W]);
      ST_RECOVER:
        val = taskFile ? CNT_W'(word[CINACT_LO +: CINACT_W])
                       : CNT_W'(word[DINACT_LO +: DINACT_W]);
      default: val = '0;
    endcase
    return val;
  endfunction

endpackage

// File: rtl/ata_strobe_dpath.sv
module ata_strobe_dpath
  import ata_strobe_pkg::*;
#(
  parameter int NUM_DEV = 2,
  localparam int DEV_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [DEV_W-1:0]  cfgDev,
  input  logic [WORD_W-1:0] cfgWord,
  input  logic [DEV_W-1:0]  reqDev,
  input  logic              reqTaskFile,
  input  logic              reqDma,
  input  ctrl_s             ctrlS,
  input  logic              busyI,
  output logic              cntZero,
  output logic              fifoEn
);

  logic [WORD_W-1:0] timWord [NUM_DEV];
  logic [WORD_W-1:0] snapWord;
  logic              snapTf;
  logic              snapFifo;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] liveWord;
  logic [WORD_W-1:0] srcWord;
  logic              srcTf;

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        timWord[d] <= '0;
      end else if (cfgWe && (int'(cfgDev) == d)) begin
        timWord[d] <= cfgWord;
      end
    end
  end

  assign liveWord = timWord[reqDev];
  assign srcWord  = ctrlS.takeSnap ? liveWord : snapWord;
  assign srcTf    = ctrlS.takeSnap ? reqTaskFile : snapTf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapWord <= '0;
      snapTf   <= 1'b0;
      snapFifo <= 1'b0;
    end else if (ctrlS.takeSnap) begin
      snapWord <= liveWord;
      snapTf   <= reqTaskFile;
      snapFifo <= liveWord[FIFO_BIT] & reqDma & ~reqTaskFile;
    end else if (ctrlS.release_) begin
      snapFifo <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctrlS.cntLoad) begin
      cnt <= phaseCount(srcWord, srcTf, ctrlS.cntSel);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign cntZero = (cnt == '0);
  assign fifoEn  = snapFifo;

  // R8
  snap_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlS.takeSnap |-> !busyI);

  // R12
  fifo_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busyI |-> !fifoEn);

endmodule

// File: rtl/ata_strobe_ctrl.sv
module ata_strobe_ctrl
  import ata_strobe_pkg::*;
#(
  parameter int NUM_DEV = 2,
  localparam int DEV_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [DEV_W-1:0] reqDev,
  input  logic             reqWrite,
  input  logic             reqTaskFile,
  input  logic             cntZero,
  output ctrl_s            ctrlS,
  output logic             busy,
  output logic             done,
  output logic             diorN,
  output logic             diowN,
  output logic             rdCapture
);

  phase_e           st;
  phase_e           stNext;
  logic             wrQ;
  logic             lastDone;
  logic [DEV_W-1:0] prevDev;
  logic             prevTf;
  logic             accept;
  logic             burst;

  assign accept = (st == ST_IDLE) && reqValid;
  assign burst  = lastDone && (reqDev == prevDev) && (reqTaskFile == prevTf);

  always_comb begin
    ctrlS  = '0;
    stNext = st;
    done   = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (reqValid) begin
          ctrlS.takeSnap = 1'b1;
          ctrlS.cntLoad  = 1'b1;
          ctrlS.cntSel   = burst ? ST_ACTIVE : ST_SETUP;
          stNext         = burst ? ST_ACTIVE : ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (cntZero) begin
          ctrlS.cntLoad = 1'b1;
          ctrlS.cntSel  = ST_ACTIVE;
          stNext        = ST_ACTIVE;
        end
      end
      ST_ACTIVE: begin
        if (cntZero) begin
          ctrlS.cntLoad = 1'b1;
          ctrlS.cntSel  = ST_RECOVER;
          stNext        = ST_RECOVER;
        end
      end
      ST_RECOVER: begin
        if (cntZero) begin
          done           = 1'b1;
          ctrlS.release_ = 1'b1;
          stNext         = ST_IDLE;
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      wrQ      <= 1'b0;
      lastDone <= 1'b0;
      prevDev  <= '0;
      prevTf   <= 1'b0;
    end else begin
      st       <= stNext;
      lastDone <= done;
      if (accept) begin
        wrQ     <= reqWrite;
        prevDev <= reqDev;
        prevTf  <= reqTaskFile;
      end
    end
  end

  assign busy      = (st != ST_IDLE);
  assign diorN     = !((st == ST_ACTIVE) && !wrQ);
  assign diowN     = !((st == ST_ACTIVE) && wrQ);
  assign rdCapture = (st == ST_ACTIVE) && !wrQ && cntZero;

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!diorN && !diowN));

  // R6
  cap_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdCapture |=> (diorN && !rdCapture));

  // R7
  done_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

endmodule

// File: rtl/ata_strobe_gen.sv
module ata_strobe_gen
  import ata_strobe_pkg::*;
#(
  parameter int NUM_DEV = 2,
  localparam int DEV_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [DEV_W-1:0]  cfgDev,
  input  logic [WORD_W-1:0] cfgWord,
  input  logic              reqValid,
  input  logic [DEV_W-1:0]  reqDev,
  input  logic              reqWrite,
  input  logic              reqTaskFile,
  input  logic              reqDma,
  output logic              busy,
  output logic              done,
  output logic              diorN,
  output logic              diowN,
  output logic              rdCapture,
  output logic              fifoEn
);

  ctrl_s ctrlS;
  logic  cntZero;

  ata_strobe_ctrl #(.NUM_DEV(NUM_DEV)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqDev     (reqDev),
    .reqWrite   (reqWrite),
    .reqTaskFile(reqTaskFile),
    .cntZero    (cntZero),
    .ctrlS      (ctrlS),
    .busy       (busy),
    .done       (done),
    .diorN      (diorN),
    .diowN      (diowN),
    .rdCapture  (rdCapture)
  );

  ata_strobe_dpath #(.NUM_DEV(NUM_DEV)) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWe      (cfgWe),
    .cfgDev     (cfgDev),
    .cfgWord    (cfgWord),
    .reqDev     (reqDev),
    .reqTaskFile(reqTaskFile),
    .reqDma     (reqDma),
    .ctrlS      (ctrlS),
    .busyI      (busy),
    .cntZero    (cntZero),
    .fifoEn     (fifoEn)
  );

endmodule

// File: tb/ata_strobe_gen_tb.sv
module ata_strobe_gen_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [0:0]  cfgDev = '0;
  logic [31:0] cfgWord = '0;
  logic        reqValid = 1'b0;
  logic [0:0]  reqDev = '0;
  logic        reqWrite = 1'b0;
  logic        reqTaskFile = 1'b0;
  logic        reqDma = 1'b0;
  logic        busy, done, diorN, diowN, rdCapture, fifoEn;

  int total = 0;
  int bad = 0;

  int mSet, mAct, mRec, mCapCnt, mCapIdx, mDone;
  bit mDirBad, mFifoBad, mTimeout;
  logic mFifo;

  always #(CLK_PERIOD/2) clk = ~clk;

  ata_strobe_gen dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgDev(cfgDev), .cfgWord(cfgWord),
    .reqValid(reqValid), .reqDev(reqDev), .reqWrite(reqWrite),
    .reqTaskFile(reqTaskFile), .reqDma(reqDma), .busy(busy), .done(done),
    .diorN(diorN), .diowN(diowN), .rdCapture(rdCapture), .fifoEn(fifoEn)
  );

  typedef struct packed {
    logic [3:0] dI;
    logic [4:0] dA;
    logic [3:0] cI;
    logic [4:0] cA;
    logic [2:0] dS;
    logic [2:0] cS;
    logic       fifo;
    logic       dev;
    logic       wr;
    logic       tf;
    logic       dma;
    logic [5:0] eSet;
    logic [5:0] eAct;
    logic [5:0] eRec;
    logic       eFifo;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{4'd2, 5'd3, 4'd5, 5'd7, 3'd1, 3'd4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'd2, 6'd4, 6'd3, 1'b0},
    '{4'd2, 5'd3, 4'd5, 5'd7, 3'd1, 3'd4, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 6'd2, 6'd4, 6'd3, 1'b1},
    '{4'd2, 5'd3, 4'd5, 5'd7, 3'd1, 3'd4, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 6'd5, 6'd8, 6'd6, 1'b0},
    '{4'd0, 5'd0, 4'd15, 5'd31, 3'd7, 3'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 6'd1, 6'd32, 6'd16, 1'b0},
    '{4'd0, 5'd0, 4'd15, 5'd31, 3'd7, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 6'd8, 6'd1, 6'd1, 1'b0},
    '{4'd15, 5'd31, 4'd0, 5'd0, 3'd0, 3'd7, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 6'd1, 6'd32, 6'd16, 1'b1}
  };

  function automatic logic [31:0] mkWord(input logic [3:0] dI, input logic [4:0] dA,
                                         input logic [3:0] cI, input logic [4:0] cA,
                                         input logic [2:0] dS, input logic [2:0] cS,
                                         input logic fifo);
    return {fifo, 3'b000, cS, dS, 4'b0000, cA, cI, dA, dI};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfgWrite(input logic dev, input logic [31:0] word);
    cfgWe = 1'b1; cfgDev = dev; cfgWord = word;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic runOne(input logic dev, input logic wr, input logic tf, input logic dma,
                        input bit midWr, input logic mDev, input logic [31:0] mWord,
                        input bit spur);
    bit started, fin, seenStb, spurOn, spurDone;
    int guard;
    reqDev = dev; reqWrite = wr; reqTaskFile = tf; reqDma = dma; reqValid = 1'b1;
    mSet = 0; mAct = 0; mRec = 0; mCapCnt = 0; mCapIdx = 0; mDone = 0;
    mDirBad = 0; mFifoBad = 0; mTimeout = 0; mFifo = 1'b0;
    started = 0; fin = 0; seenStb = 0; spurOn = 0; spurDone = 0; guard = 0;
    while (!fin) begin
      @(negedge clk);
      guard++;
      if (guard > 300) begin
        mTimeout = 1; fin = 1; reqValid = 1'b0;
      end else if (busy) begin
        if (!started) begin
          started = 1; reqValid = 1'b0;
          if (midWr) begin cfgWe = 1'b1; cfgDev = mDev; cfgWord = mWord; end
        end else begin
          cfgWe = 1'b0;
        end
        if (!diorN || !diowN) begin
          mAct++; seenStb = 1;
          if (wr && (diowN || !diorN)) mDirBad = 1;
          if (!wr && (diorN || !diowN)) mDirBad = 1;
        end else if (!seenStb) begin
          mSet++;
        end else begin
          mRec++;
        end
        if (rdCapture) begin mCapCnt++; mCapIdx = mAct; end
        if (mSet + mAct + mRec == 1) mFifo = fifoEn;
        else if (fifoEn !== mFifo) mFifoBad = 1;
        if (spur) begin
          if (spurOn) begin reqValid = 1'b0; spurOn = 0; spurDone = 1; end
          else if (mAct == 2 && !spurDone) begin reqValid = 1'b1; reqDev = ~dev; spurOn = 1; end
        end
        if (done) begin mDone++; fin = 1; end
      end
    end
    cfgWe = 1'b0;
  endtask

  task automatic checkXfer(input string tag, input int eSet, input int eAct, input int eRec,
                           input logic wr, input logic eFifo);
    chk(!mTimeout, {tag, " completes"}, mTimeout, 0);
    chk(mSet == eSet, {tag, " setup clocks R4"}, mSet, eSet);
    chk(mAct == eAct, {tag, " active clocks R2/R3"}, mAct, eAct);
    chk(mRec == eRec, {tag, " recovery clocks R2/R3"}, mRec, eRec);
    if (wr) chk(mCapCnt == 0, {tag, " no capture on write R6"}, mCapCnt, 0);
    else    chk(mCapCnt == 1 && mCapIdx == eAct, {tag, " capture at last active clock R6"}, mCapIdx, eAct);
    chk(!mDirBad, {tag, " strobe direction R5"}, mDirBad, 0);
    chk(!mFifoBad && mFifo == eFifo, {tag, " fifo enable R12"}, mFifo, eFifo);
    chk(mDone == 1, {tag, " single done R7"}, mDone, 1);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    @(negedge clk);
    chk(diorN && diowN && !busy && !done && !rdCapture && !fifoEn, "R1 outputs in reset", busy, 0);
    gap(2);
    rstN = 1'b1;
    gap(2);
    chk(diorN && diowN && !busy && !done && !rdCapture && !fifoEn, "R1 outputs after reset", busy, 0);
    runOne(1'b0, 1'b0, 1'b1, 1'b0, 0, 1'b0, '0, 0);
    checkXfer("R1 cleared word", 1, 1, 1, 1'b0, 1'b0);
    gap(3);

    // table walk: R2 R3 R4 R5 R6 R12
    for (int i = 0; i < NVEC; i++) begin
      cfgWrite(VECS[i].dev, mkWord(VECS[i].dI, VECS[i].dA, VECS[i].cI, VECS[i].cA,
                                   VECS[i].dS, VECS[i].cS, VECS[i].fifo));
      gap(3);
      runOne(VECS[i].dev, VECS[i].wr, VECS[i].tf, VECS[i].dma, 0, 1'b0, '0, 0);
      checkXfer($sformatf("vector %0d", i), VECS[i].eSet, VECS[i].eAct, VECS[i].eRec,
                VECS[i].wr, VECS[i].eFifo);
      gap(3);
    end

    // R11: device 0 keeps its word after device 1 is rewritten
    cfgWrite(1'b1, mkWord(4'd1, 5'd1, 4'd1, 5'd1, 3'd1, 3'd1, 1'b0));
    gap(3);
    runOne(1'b0, 1'b1, 1'b0, 1'b1, 0, 1'b0, '0, 0);
    checkXfer("R11 other device untouched", 1, 32, 16, 1'b1, 1'b1);
    gap(3);

    // R9 back-to-back setup skip
    cfgWrite(1'b0, mkWord(4'd1, 5'd1, 4'd0, 5'd0, 3'd3, 3'd2, 1'b0));
    cfgWrite(1'b1, mkWord(4'd0, 5'd0, 4'd0, 5'd0, 3'd5, 3'd0, 1'b0));
    gap(3);
    runOne(1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0, '0, 0);
    checkXfer("R9 first of burst", 4, 2, 2, 1'b0, 1'b0);
    runOne(1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0, '0, 0);
    checkXfer("R9 same device and class skips setup", 0, 2, 2, 1'b0, 1'b0);
    runOne(1'b0, 1'b1, 1'b1, 1'b0, 0, 1'b0, '0, 0);
    checkXfer("R9 class change keeps setup", 3, 1, 1, 1'b1, 1'b0);
    runOne(1'b1, 1'b0, 1'b0, 1'b0, 0, 1'b0, '0, 0);
    checkXfer("R9 device change keeps setup", 6, 1, 1, 1'b0, 1'b0);
    gap(2);
    runOne(1'b1, 1'b0, 1'b0, 1'b0, 0, 1'b0, '0, 0);
    checkXfer("R9 gap keeps setup", 6, 1, 1, 1'b0, 1'b0);
    gap(3);

    // R10 word written during a transfer
    cfgWrite(1'b0, mkWord(4'd2, 5'd2, 4'd0, 5'd0, 3'd1, 3'd0, 1'b0));
    gap(3);
    runOne(1'b0, 1'b1, 1'b0, 1'b0, 1, 1'b0, mkWord(4'd4, 5'd5, 4'd0, 5'd0, 3'd2, 3'd0, 1'b0), 0);
    checkXfer("R10 current transfer keeps old word", 2, 3, 3, 1'b1, 1'b0);
    gap(3);
    runOne(1'b0, 1'b1, 1'b0, 1'b0, 0, 1'b0, '0, 0);
    checkXfer("R10 next transfer uses new word", 3, 6, 5, 1'b1, 1'b0);
    gap(3);

    // R8 request pulsed while busy is ignored
    cfgWrite(1'b0, mkWord(4'd0, 5'd5, 4'd0, 5'd0, 3'd0, 3'd0, 1'b0));
    cfgWrite(1'b1, mkWord(4'd0, 5'd0, 4'd0, 5'd0, 3'd0, 3'd0, 1'b0));
    gap(3);
    runOne(1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0, '0, 1);
    checkXfer("R8 transfer with stray request", 1, 6, 1, 1'b0, 1'b0);
    begin
      bit stray = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (busy || !diorN || !diowN) stray = 1;
      end
      chk(!stray, "R8 stray request started no transfer", stray, 0);
    end

    // R1 reset during an active strobe clears words
    cfgWrite(1'b0, mkWord(4'd3, 5'd9, 4'd3, 5'd9, 3'd2, 3'd2, 1'b1));
    gap(2);
    reqDev = 1'b0; reqWrite = 1'b1; reqTaskFile = 1'b0; reqDma = 1'b1; reqValid = 1'b1;
    begin
      int g = 0;
      while (diowN && g < 50) begin
        @(negedge clk); g++;
        if (busy) reqValid = 1'b0;
      end
    end
    reqValid = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    chk(diorN && diowN && !busy && !fifoEn && !done, "R1 reset mid-strobe releases outputs", diowN, 1);
    rstN = 1'b1;
    gap(2);
    runOne(1'b0, 1'b1, 1'b0, 1'b1, 0, 1'b0, '0, 0);
    checkXfer("R1 words cleared by reset", 1, 1, 1, 1'b1, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule